// File: doc/BRIEF.md
# Video Data-Port Write Steering Unit

This unit sits behind the data port of a video processor. Each byte written to that port goes to one of two memories. The choice depends on the access code that the last control command left behind.

Any code other than the colour-write code sends the byte to video RAM at the current address. The colour-write code sends the byte to colour RAM through a one-byte holding latch:

- On an even address, the byte is only held in the latch.
- On an odd address, the held byte and the incoming byte are written together as one pair. This lets a two-byte colour entry change in a single step.

The unit also keeps the auto-incrementing address and the access code loaded by the control port. It tracks whether the control port is halfway through a two-byte command; a data-port write cancels such a half-finished command. The two memories sit outside the unit and are driven through plain write ports.

Top module: `vdw_steer`

## Requirements
- R1: A synchronous active-high reset sets the address, the colour latch and the pending flag to zero, and the held access code to 0. After reset, a paired colour write therefore places 0x00 in the even entry.
- R2: When the held code is not 3, a data write asserts `vram_we_o` in the same cycle, with `vram_addr_o` equal to the current address and `vram_data_o` equal to the byte. Colour RAM is not written.
- R3: When the held code is 3 and address bit 0 is 0, a data write asserts no write strobe on either memory and only loads the byte into the colour latch.
- R4: When the held code is 3 and address bit 0 is 1, a data write asserts `cram_we_o` for one cycle. It writes the latch to the even entry and the byte, with bits 7:4 forced to zero, to the odd entry.
- R5: The colour pair index `cram_pair_o` is address bits 5:1, so colour addressing wraps within 64 bytes.
- R6: Every data write increments the 14-bit address by one, wrapping from 0x3FFF to 0x0000.
- R7: `cmd_load_i` loads the address and the access code on the next edge and clears the pending flag. A data write in the same cycle still uses the old address and code.
- R8: `ctl_half_i` sets the pending flag. A data write clears it, and the clear wins when both arrive in the same cycle.
- R9: The colour latch changes only on an even-address colour write. Video writes, odd writes and command loads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_half_i | input | 1 | First byte of a two-byte control command arrived |
| cmd_load_i | input | 1 | Complete command: load address and code |
| cmd_code_i | input | 2 | Access code of the command (3 = colour write) |
| cmd_addr_i | input | 14 | Address of the command |
| data_wr_i | input | 1 | Data-port write strobe |
| data_i | input | 8 | Data-port byte |
| vram_we_o | output | 1 | Video RAM write enable |
| vram_addr_o | output | 14 | Video RAM write address |
| vram_data_o | output | 8 | Video RAM write byte |
| cram_we_o | output | 1 | Colour RAM pair write enable |
| cram_pair_o | output | 5 | Colour RAM pair index |
| cram_even_o | output | 8 | Byte for the even entry of the pair |
| cram_odd_o | output | 8 | Byte for the odd entry of the pair |
| addr_o | output | 14 | Current address |
| ctl_pending_o | output | 1 | Control command half received |

## Verification
A corrupted colour latch stays hidden until the next odd colour write. It then shows up as a wrong `cram_even_o` in that same cycle. For this reason the bench places video writes and command loads between the even write and the odd write, so the latch must hold its value across them. A wrong address or code shows up on the next data write's strobe or address, and `addr_o` exposes it one edge after the faulty update. The bench model compares every output on every clock, so an error is reported in the first cycle it reaches a port.

// File: rtl/vdw_pkg.sv
package vdw_pkg;
    localparam int ADDR_W  = 14;
    localparam int DATA_W  = 8;
    localparam int CRAM_AW = 6;
    localparam int CODE_W  = 2;
    localparam int KEEP_W  = 4;

    typedef enum logic [CODE_W-1:0] {
        ACC_VRD = 2'd0,
        ACC_VWR = 2'd1,
        ACC_REG = 2'd2,
        ACC_CWR = 2'd3
    } acc_code_e;

    function automatic logic [DATA_W-1:0] odd_trim(input logic [DATA_W-1:0] b);
        return {{(DATA_W-KEEP_W){1'b0}}, b[KEEP_W-1:0]};
    endfunction
endpackage

// File: rtl/vdw_addr_ctl.sv
module vdw_addr_ctl
    import vdw_pkg::*;
#(
    parameter int AW = vdw_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_half,
    input  logic          cmd_load,
    input  acc_code_e     cmd_code,
    input  logic [AW-1:0] cmd_addr,
    input  logic          data_wr,
    output logic [AW-1:0] addr_q,
    output acc_code_e     code_q,
    output logic          pend_q
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            code_q <= ACC_VRD;
            pend_q <= 1'b0;
        end else begin
            if (cmd_load) begin
                addr_q <= cmd_addr;
                code_q <= cmd_code;
            end else if (data_wr) begin
                addr_q <= addr_q + ONE;
            end
            if (cmd_load || data_wr)
                pend_q <= 1'b0;
            else if (ctl_half)
                pend_q <= 1'b1;
        end
    end

    // R6: address steps by one (with wrap) after a data write
    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !cmd_load) |=> addr_q == AW'($past(addr_q) + ONE));
    // R7: command load takes the supplied address
    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        cmd_load |=> (addr_q == $past(cmd_addr)) && !pend_q);
    // R8: a data write cancels a half-received command
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> !pend_q);
endmodule

// File: rtl/vdw_cram_latch.sv
module vdw_cram_latch #(
    parameter int DW = vdw_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '0;
        else if (capture)
            latch_q <= din;
    end

    // R9: latch holds unless an even colour write captures
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(latch_q));
    // R3: captured byte is what was presented
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        capture |=> latch_q == $past(din));
endmodule

// File: rtl/vdw_steer.sv
module vdw_steer
    import vdw_pkg::*;
#(
    parameter int AW  = vdw_pkg::ADDR_W,
    parameter int DW  = vdw_pkg::DATA_W,
    parameter int CAW = vdw_pkg::CRAM_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ctl_half_i,
    input  logic           cmd_load_i,
    input  logic [1:0]     cmd_code_i,
    input  logic [AW-1:0]  cmd_addr_i,
    input  logic           data_wr_i,
    input  logic [DW-1:0]  data_i,
    output logic           vram_we_o,
    output logic [AW-1:0]  vram_addr_o,
    output logic [DW-1:0]  vram_data_o,
    output logic           cram_we_o,
    output logic [CAW-2:0] cram_pair_o,
    output logic [DW-1:0]  cram_even_o,
    output logic [DW-1:0]  cram_odd_o,
    output logic [AW-1:0]  addr_o,
    output logic           ctl_pending_o
);
    logic [AW-1:0] addr_q;
    acc_code_e     code_q;
    logic          pend_q;
    logic [DW-1:0] latch_q;
    logic          to_cram;
    logic          hold_even;

    vdw_addr_ctl #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .ctl_half (ctl_half_i),
        .cmd_load (cmd_load_i),
        .cmd_code (acc_code_e'(cmd_code_i)),
        .cmd_addr (cmd_addr_i),
        .data_wr  (data_wr_i),
        .addr_q   (addr_q),
        .code_q   (code_q),
        .pend_q   (pend_q)
    );

    assign to_cram   = (code_q == ACC_CWR);
    assign hold_even = data_wr_i && to_cram && !addr_q[0];

    vdw_cram_latch #(.DW(DW)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (hold_even),
        .din     (data_i),
        .latch_q (latch_q)
    );

    always_comb begin
        vram_we_o   = data_wr_i && !to_cram;
        vram_addr_o = addr_q;
        vram_data_o = data_i;
        cram_we_o   = data_wr_i && to_cram && addr_q[0];
        cram_pair_o = addr_q[CAW-1:1];
        cram_even_o = latch_q;
        cram_odd_o  = odd_trim(data_i);
    end

    assign addr_o        = addr_q;
    assign ctl_pending_o = pend_q;

    // R2: never both memories at once
    a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
        !(vram_we_o && cram_we_o));
    // R4: colour pair write only on a data strobe, high nibble cleared
    a_r4_pair: assert property (@(posedge clk) disable iff (rst)
        cram_we_o |-> data_wr_i && cram_odd_o[DW-1:KEEP_W] == '0);
    // R3: even colour write touches neither memory
    a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
        hold_even |-> !vram_we_o && !cram_we_o);
endmodule

// File: tb/vdw_steer_test.sv
module vdw_steer_test;
    logic clk = 1'b0;
    logic rst, ctl_half, cmd_load, data_wr;
    logic [1:0]  cmd_code;
    logic [13:0] cmd_addr;
    logic [7:0]  data;
    logic        vram_we, cram_we, pend;
    logic [13:0] vram_addr, addr;
    logic [7:0]  vram_data, c_even, c_odd;
    logic [4:0]  c_pair;

    int n_cmp = 0;
    int n_bad = 0;
    int m_addr, m_code, m_latch, m_pend;

    always #10 clk = ~clk;

    vdw_steer uut (
        .clk(clk), .rst(rst), .ctl_half_i(ctl_half), .cmd_load_i(cmd_load),
        .cmd_code_i(cmd_code), .cmd_addr_i(cmd_addr), .data_wr_i(data_wr),
        .data_i(data), .vram_we_o(vram_we), .vram_addr_o(vram_addr),
        .vram_data_o(vram_data), .cram_we_o(cram_we), .cram_pair_o(c_pair),
        .cram_even_o(c_even), .cram_odd_o(c_odd), .addr_o(addr),
        .ctl_pending_o(pend)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare mid-cycle, advance model at edge
    task automatic cyc(input logic r, input logic h, input logic ld,
                       input int code, input int a, input logic w, input int d);
        bit is_c, odd;
        @(negedge clk);
        rst = r; ctl_half = h; cmd_load = ld; cmd_code = code[1:0];
        cmd_addr = a[13:0]; data_wr = w; data = d[7:0];
        #2;
        is_c = (m_code == 3);
        odd  = m_addr[0];
        chk("R6 addr_o", addr, m_addr);
        chk("R8 pending", pend, m_pend);
        chk("R2 vram_we", vram_we, w && !is_c);
        if (w && !is_c) begin
            chk("R2 vram_addr", vram_addr, m_addr);
            chk("R2 vram_data", vram_data, d & 8'hFF);
        end
        chk("R3/R4 cram_we", cram_we, w && is_c && odd);
        if (w && is_c && odd) begin
            chk("R5 cram_pair", c_pair, (m_addr & 63) >> 1);
            chk("R9 cram_even", c_even, m_latch);
            chk("R4 cram_odd", c_odd, d & 8'h0F);
        end
        if (r) begin
            m_addr = 0; m_code = 0; m_latch = 0; m_pend = 0;
        end else begin
            if (w && is_c && !odd) m_latch = d & 8'hFF;
            if (ld) begin m_addr = a & 16'h3FFF; m_code = code; end
            else if (w) m_addr = (m_addr + 1) & 16'h3FFF;
            if (ld || w) m_pend = 0;
            else if (h) m_pend = 1;
        end
    endtask

    task automatic wr(input int d);  cyc(0, 0, 0, 0, 0, 1, d); endtask
    task automatic cmd(input int c, input int a); cyc(0, 0, 1, c, a, 0, 0); endtask
    task automatic idle();           cyc(0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        m_addr = 0; m_code = 0; m_latch = 0; m_pend = 0;
        rst = 1; ctl_half = 0; cmd_load = 0; cmd_code = 0; cmd_addr = 0;
        data_wr = 0; data = 0;
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        idle();                        // R1: reset state on outputs
        // R2, R6: video writes with code 1 then code 0
        cmd(1, 14'h0123);
        for (int i = 0; i < 4; i++) wr(8'h10 + i * 8'h21);
        cmd(0, 14'h2000);
        wr(8'hC3);
        // R6: wrap at the 14-bit boundary
        cmd(1, 14'h3FFE);
        wr(8'h01); wr(8'h02); wr(8'h03);
        // R3, R4, R5: colour pair at address 0x1C4 (low six bits 0x04)
        cmd(3, 14'h01C4);
        wr(8'hAB); wr(8'hFF);
        // R9: latch held across video write and command loads
        wr(8'h77);                     // even, latch = 0x77
        cmd(1, 14'h0040); wr(8'h99);
        cmd(3, 14'h3FFF); wr(8'h5A);   // odd, even = 0x77, pair 31
        // R5: wrap inside colour space from 0x3F to 0x00
        wr(8'h44); wr(8'hE6);
        // R7: load and write in the same cycle
        cyc(0, 0, 1, 1, 14'h0100, 1, 8'h3C);
        wr(8'h3D);
        // R8: half command, then cleared by data write; same-cycle clear wins
        cyc(0, 1, 0, 0, 0, 0, 0);
        idle();
        wr(8'h11);
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 1, 8'h22);
        cyc(0, 1, 0, 0, 0, 0, 0);
        cmd(3, 14'h0010);              // R7: load clears pending
        // R1: reset mid-run clears latch
        wr(8'hBE);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cmd(3, 14'h0011);
        wr(8'hF7);
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule